// File: doc/BRIEF.md
# Burst SPI Master with Byte FIFOs

This block is a register-mapped SPI master that runs one framed burst per start command. Software loads a 64-byte transmit FIFO through a 32-bit register bus, programs a burst length and a transmit length, and sets a start bit. The controller lowers chip select and clocks out whole bytes in SPI mode 0, MSB first. Each byte it clocks is also captured into a 64-byte receive FIFO. Once the transmit length is used up, the controller keeps clocking zero bytes until the burst length is reached. It then raises chip select and clears the start bit.

The data registers accept byte or word access. A word access moves four bytes, little-endian. A single status word reports both FIFO fill levels, so software can stream bursts longer than the FIFO by polling it. The SCLK rate is set by a divider register. If the transmit FIFO runs dry while bytes are still owed, the controller holds SCLK low and resumes when data arrives.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, and the control (0x00), status (0x10), burst length (0x08) and transmit length (0x0C) registers all read 0.
- R2: The status register at 0x10 holds the RX FIFO byte count in bits [6:0] and the TX FIFO byte count in bits [22:16]. All other bits read 0.
- R3: A write to 0x14 pushes one byte (wdata_i[7:0]) when word_i is 0. When word_i is 1 it pushes four bytes, lowest byte lane first.
- R4: A read of 0x18 pops one byte into rdata_o[7:0] when word_i is 0. When word_i is 1 it pops up to four bytes, the oldest in rdata_o[7:0].
- R5: A burst runs only while control bits 0 (enable) and 1 (master) are both set. It starts when control bit 10 is written as 1. During the whole burst cs_no is low and SCLK idles low. MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and bits go MSB first.
- R6: A burst clocks exactly the burst length (0x08) of bytes. The first transmit-length (0x0C) bytes come from the TX FIFO and the rest are 0x00. Every clocked byte is pushed into the RX FIFO.
- R7: Control bit 10 reads 1 while a burst runs. Hardware clears it, and raises cs_no, in the same cycle the burst ends.
- R8: While transmit bytes are still owed and the TX FIFO is empty, SCLK stays low and the burst waits. It resumes when a byte is written.
- R9: The divider register at 0x04 makes the SCLK period 2*(N+1) clock cycles, where N is bits [7:0]. So 0x1000 gives divide by 2 and 0x1001 gives divide by 4.
- R10: Writing 1 to control bit 8 empties the TX FIFO, and writing 1 to bit 9 empties the RX FIFO. Neither bit is stored.
- R11: Writing 1 to control bit 31 performs a soft reset. It empties both FIFOs, clears the control, divider and length registers, and then bit 31 reads 0 again.
- R12: A read of an empty RX FIFO returns 0 and leaves the fill level unchanged.
- R13: Each FIFO holds 64 bytes. Bytes written to a full TX FIFO are dropped, and the count never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access (pops RX data) |
| word_i | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sclk_o | output | 1 | SPI clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The hardest state to reach from the ports is a burst that stalls partway through on an empty TX FIFO. Reaching it needs a transmit length larger than what was preloaded. The stimulus preloads only one byte of a two-byte burst and waits far longer than a byte time. It then checks that exactly eight rising SCLK edges occurred and that chip select and the start bit are still held. Only after that does it write the missing byte. Random bursts vary the divider, the burst and transmit lengths, and the mix of byte and word accesses. A bench slave model returns a known per-position byte, which exposes any misplaced lane or bit.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_DIV   = 8'h04;
  localparam logic [7:0] A_BURST = 8'h08;
  localparam logic [7:0] A_TXLEN = 8'h0C;
  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_TXD   = 8'h14;
  localparam logic [7:0] A_RXD   = 8'h18;

  localparam int B_EN    = 0;
  localparam int B_MST   = 1;
  localparam int B_TXRST = 8;
  localparam int B_RXRST = 9;
  localparam int B_XCH   = 10;
  localparam int B_SRST  = 31;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_LOW,
    S_HIGH
  } eng_state_e;
endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [NW-1:0]      push_n_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic [NW-1:0]      pop_n_i,
  output logic [8*LANES-1:0] peek_o,
  output logic [CW-1:0]      count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, free_w, push_acc, pop_acc;

  assign free_w   = CW'(DEPTH) - count_q;
  assign push_acc = (CW'(push_n_i) > free_w) ? free_w : CW'(push_n_i);
  assign pop_acc  = (CW'(pop_n_i) > count_q) ? count_q : CW'(pop_n_i);

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (!clr_i && CW'(k) < push_acc) mem_q[wptr_q + AW'(k)] <= push_data_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_q + AW'(push_acc);
      rptr_q  <= rptr_q + AW'(pop_acc);
      count_q <= count_q + push_acc - pop_acc;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_o[8*g +: 8] = (CW'(g) < count_q) ? mem_q[rptr_q + AW'(g)] : 8'h00;
  end

  assign count_o = count_q;

  p_no_overflow_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  p_empty_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_n_i != '0 && push_n_i == '0 && !clr_i) |=> count_q == '0);
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
  import spi_bm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] burst_len_i,
  input  logic [CNT_W-1:0] tx_len_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             tx_empty_i,
  input  logic [7:0]       tx_data_i,
  input  logic             miso_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_no
);
  eng_state_e       state_q;
  logic [CNT_W-1:0] burst_q, txl_q, bytes_q;
  logic [DIV_W-1:0] half_q, div_q;
  logic [7:0]       sh_q, rx_sh_q;
  logic [2:0]       bit_q;
  logic             sclk_q, cs_q;
  logic             at_end, edge_w;

  assign at_end = (bytes_q == burst_q);
  assign edge_w = (div_q == half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      burst_q <= '0;
      txl_q   <= '0;
      bytes_q <= '0;
      half_q  <= '0;
      div_q   <= '0;
      sh_q    <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else if (clr_i) begin
      state_q <= S_IDLE;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      div_q   <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cs_q    <= 1'b0;
          bytes_q <= '0;
          burst_q <= burst_len_i;
          txl_q   <= (tx_len_i > burst_len_i) ? burst_len_i : tx_len_i;
          half_q  <= half_i;
          state_q <= S_LOAD;
        end
        S_LOAD: begin
          div_q <= '0;
          bit_q <= '0;
          if (at_end) begin
            cs_q    <= 1'b1;
            state_q <= S_IDLE;
          end else if (txl_q != '0) begin
            if (!tx_empty_i) begin
              sh_q    <= tx_data_i;
              txl_q   <= txl_q - 1'b1;
              state_q <= S_LOW;
            end
          end else begin
            sh_q    <= 8'h00;
            state_q <= S_LOW;
          end
        end
        S_LOW: begin
          if (edge_w) begin
            sclk_q  <= 1'b1;
            rx_sh_q <= {rx_sh_q[6:0], miso_i};
            div_q   <= '0;
            state_q <= S_HIGH;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        S_HIGH: begin
          if (edge_w) begin
            sclk_q <= 1'b0;
            div_q  <= '0;
            if (bit_q == 3'd7) begin
              bytes_q <= bytes_q + 1'b1;
              state_q <= S_LOAD;
            end else begin
              sh_q    <= {sh_q[6:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
              state_q <= S_LOW;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_pop_o  = (state_q == S_LOAD) && !at_end && (txl_q != '0) && !tx_empty_i && !clr_i;
  assign rx_push_o = (state_q == S_HIGH) && edge_w && (bit_q == 3'd7) && !clr_i;
  assign rx_data_o = rx_sh_q;
  assign done_o    = (state_q == S_LOAD) && at_end && !clr_i;
  assign busy_o    = (state_q != S_IDLE);
  assign sclk_o    = sclk_q;
  assign cs_no     = cs_q;
  assign mosi_o    = cs_q ? 1'b0 : sh_q[7];

  p_sclk_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  p_mosi_stable_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sclk_o && tx_empty_i && txl_q != '0 && state_q == S_LOAD && !clr_i) |=> !sclk_o);

  p_cs_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && !$past(clr_i)) |-> $past(done_o));
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_bm_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  parameter int DIV_W      = 8,
  parameter int ADDR_W     = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              word_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic             en_q, mst_q, xch_q, srst_q;
  logic [15:0]      div_q;
  logic [CNT_W-1:0] burst_q, txlen_q;
  logic             wr_ctrl, wr_txd, rd_rxd;
  logic             tx_clr, rx_clr;
  logic [2:0]       tx_push_n, rx_pop_n;
  logic [31:0]      tx_peek, rx_peek;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_pop, rx_push, busy, done, start;
  logic [7:0]       rx_byte;

  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_txd  = wr_i && (addr_i == ADDR_W'(A_TXD));
  assign rd_rxd  = rd_i && (addr_i == ADDR_W'(A_RXD));
  assign tx_clr  = srst_q || (wr_ctrl && wdata_i[B_TXRST]);
  assign rx_clr  = srst_q || (wr_ctrl && wdata_i[B_RXRST]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      xch_q   <= 1'b0;
      srst_q  <= 1'b0;
      div_q   <= '0;
      burst_q <= '0;
      txlen_q <= '0;
    end else if (srst_q) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      xch_q   <= 1'b0;
      srst_q  <= 1'b0;
      div_q   <= '0;
      burst_q <= '0;
      txlen_q <= '0;
    end else begin
      if (done) xch_q <= 1'b0;
      if (wr_ctrl) begin
        en_q   <= wdata_i[B_EN];
        mst_q  <= wdata_i[B_MST];
        srst_q <= wdata_i[B_SRST];
        if (wdata_i[B_XCH]) xch_q <= 1'b1;
      end
      if (wr_i && addr_i == ADDR_W'(A_DIV))   div_q   <= wdata_i[15:0];
      if (wr_i && addr_i == ADDR_W'(A_BURST)) burst_q <= wdata_i[CNT_W-1:0];
      if (wr_i && addr_i == ADDR_W'(A_TXLEN)) txlen_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign start     = xch_q && en_q && mst_q && !busy && !srst_q;
  assign tx_push_n = wr_txd ? (word_i ? 3'd4 : 3'd1) : 3'd0;
  assign rx_pop_n  = rd_rxd ? (word_i ? 3'd4 : 3'd1) : 3'd0;

  spi_bm_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tx_clr),
    .push_n_i    (tx_push_n),
    .push_data_i (wdata_i),
    .pop_n_i     ({2'b00, tx_pop}),
    .peek_o      (tx_peek),
    .count_o     (tx_cnt)
  );

  spi_bm_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_clr),
    .push_n_i    ({2'b00, rx_push}),
    .push_data_i ({24'h0, rx_byte}),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );

  spi_bm_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_q),
    .start_i     (start),
    .burst_len_i (burst_q),
    .tx_len_i    (txlen_q),
    .half_i      (div_q[DIV_W-1:0]),
    .tx_empty_i  (tx_cnt == '0),
    .tx_data_i   (tx_peek[7:0]),
    .miso_i      (miso_i),
    .tx_pop_o    (tx_pop),
    .rx_push_o   (rx_push),
    .rx_data_o   (rx_byte),
    .busy_o      (busy),
    .done_o      (done),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cs_no       (cs_no)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL): begin
        rdata_o[B_EN]   = en_q;
        rdata_o[B_MST]  = mst_q;
        rdata_o[B_XCH]  = xch_q;
        rdata_o[B_SRST] = srst_q;
      end
      ADDR_W'(A_DIV):   rdata_o[15:0] = div_q;
      ADDR_W'(A_BURST): rdata_o[CNT_W-1:0] = burst_q;
      ADDR_W'(A_TXLEN): rdata_o[CNT_W-1:0] = txlen_q;
      ADDR_W'(A_STAT): begin
        rdata_o[6:0]   = 7'(rx_cnt);
        rdata_o[22:16] = 7'(tx_cnt);
      end
      ADDR_W'(A_RXD):   rdata_o = word_i ? rx_peek : {24'h0, rx_peek[7:0]};
      default:          rdata_o = '0;
    endcase
  end

  p_xch_while_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !srst_q) |-> xch_q);

  p_srst_selfclear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q);

  p_needs_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(en_q && mst_q));
endmodule

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, word = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_burst_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .word_i(word),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // slave model
  logic [7:0] mosi_log [256];
  int         log_n = 0;
  int         sk = 0, sb = 0;
  logic [7:0] s_sh = '0;
  int         rise_cnt = 0;
  time        t1 = 0, t2 = 0;
  bit         mosi_moved_high = 1'b0;

  function automatic logic [7:0] resp(int k);
    return 8'hA5 ^ 8'(k * 29);
  endfunction

  always @(negedge cs_n) begin
    sk = 0; sb = 0; miso = resp(0)[7];
  end
  always @(posedge sclk) begin
    rise_cnt++;
    if (rise_cnt == 1) t1 = $time;
    if (rise_cnt == 2) t2 = $time;
    s_sh = {s_sh[6:0], mosi};
    sb++;
    if (sb == 8) begin
      mosi_log[log_n] = s_sh;
      log_n++;
      sb = 0;
    end
  end
  always @(negedge sclk) begin
    if (sb == 0) sk++;
    miso = resp(sk)[7 - sb];
  end
  always @(mosi) if (sclk && !cs_n) mosi_moved_high = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic w);
    @(negedge clk); addr = a; wdata = d; word = w; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk); addr = a; word = w; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(8'h00, 1'b1, v);
      if (!v[10]) begin ok = 1'b1; break; end
    end
  endtask

  // one burst: len bytes, txl from FIFO, divider n
  task automatic run_burst(input int len, input int txl, input int n);
    logic [7:0]  txb [64];
    logic [31:0] v;
    bit          ok;
    int          i;
    int          base;
    for (int k = 0; k < txl; k++) txb[k] = 8'($urandom);
    bus_wr(8'h04, 32'h1000 | n, 1'b1);
    bus_wr(8'h08, len, 1'b1);
    bus_wr(8'h0C, txl, 1'b1);
    i = 0;
    while (i < txl) begin
      if (txl - i >= 4 && $urandom_range(0, 1) == 1) begin
        bus_wr(8'h14, {txb[i+3], txb[i+2], txb[i+1], txb[i]}, 1'b1);
        i += 4;
      end else begin
        bus_wr(8'h14, {24'h0, txb[i]}, 1'b0);
        i += 1;
      end
    end
    base = log_n;
    mosi_moved_high = 1'b0;
    bus_wr(8'h00, 32'h403, 1'b1);
    @(negedge clk);
    bus_rd(8'h00, 1'b1, v);
    chk(v[10] == 1'b1 && cs_n == 1'b0, "R7 xch set while running", v, 32'h403);
    wait_done(ok);
    chk(ok, "R7 xch self-clear", 32'(ok), 1);
    chk(cs_n == 1'b1, "R7 cs released", 32'(cs_n), 1);
    chk(log_n - base == len, "R6 byte count clocked", log_n - base, len);
    chk(!mosi_moved_high, "R5 mosi stable while sclk high", 32'(mosi_moved_high), 0);
    for (int k = 0; k < len; k++) begin
      logic [7:0] e;
      e = (k < txl) ? txb[k] : 8'h00;
      chk(mosi_log[base + k] == e, "R6 mosi byte", mosi_log[base + k], e);
    end
    bus_rd(8'h10, 1'b1, v);
    chk(v == 32'(len), "R2 rx level after burst", v, len);
    i = 0;
    while (i < len) begin
      if (len - i >= 4 && $urandom_range(0, 1) == 1) begin
        bus_rd(8'h18, 1'b1, v);
        chk(v == {resp(i+3), resp(i+2), resp(i+1), resp(i)}, "R4 word rx read", v,
            {resp(i+3), resp(i+2), resp(i+1), resp(i)});
        i += 4;
      end else begin
        bus_rd(8'h18, 1'b0, v);
        chk(v == {24'h0, resp(i)}, "R4 byte rx read", v, {24'h0, resp(i)});
        i += 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 pins at reset", {cs_n, sclk}, 2'b10);
    bus_rd(8'h00, 1'b1, v); chk(v == 0, "R1 ctrl reset", v, 0);
    bus_rd(8'h10, 1'b1, v); chk(v == 0, "R1 status reset", v, 0);
    bus_rd(8'h08, 1'b1, v); chk(v == 0, "R1 burst reset", v, 0);
    bus_rd(8'h0C, 1'b1, v); chk(v == 0, "R1 txlen reset", v, 0);

    // R12 empty read
    bus_rd(8'h18, 1'b1, v); chk(v == 0, "R12 empty read data", v, 0);
    bus_rd(8'h10, 1'b1, v); chk(v == 0, "R12 level unchanged", v, 0);

    // R3 / R2 push levels
    bus_wr(8'h14, 32'h44332211, 1'b1);
    bus_wr(8'h14, 32'hFFFFFF55, 1'b0);
    bus_rd(8'h10, 1'b1, v); chk(v == 32'h0005_0000, "R2 R3 tx level", v, 32'h0005_0000);

    // R10 tx flush
    bus_wr(8'h00, 32'h100, 1'b1);
    bus_rd(8'h10, 1'b1, v); chk(v == 0, "R10 tx flush", v, 0);
    bus_rd(8'h00, 1'b1, v); chk(v == 0, "R10 bits not stored", v, 0);

    // R13 overflow
    for (int k = 0; k < 17; k++) bus_wr(8'h14, 32'(k), 1'b1);
    bus_rd(8'h10, 1'b1, v); chk(v == 32'h0040_0000, "R13 tx full at 64", v, 32'h0040_0000);
    bus_wr(8'h00, 32'h100, 1'b1);

    // R3 lane order through a burst (div /2)
    begin
      int base;
      base = log_n;
      bus_wr(8'h04, 32'h1000, 1'b1);
      bus_wr(8'h08, 4, 1'b1);
      bus_wr(8'h0C, 4, 1'b1);
      bus_wr(8'h14, 32'hDDCCBBAA, 1'b1);
      bus_wr(8'h00, 32'h403, 1'b1);
      wait_done(ok);
      chk(mosi_log[base] == 8'hAA && mosi_log[base+3] == 8'hDD, "R3 word lane order",
          {mosi_log[base], mosi_log[base+3]}, 16'hAADD);
      // R5 without master bit no burst
      bus_wr(8'h00, 32'h200, 1'b1);
      bus_wr(8'h00, 32'h401, 1'b1);
      repeat (40) @(negedge clk);
      chk(cs_n == 1'b1 && log_n == base + 4, "R5 no burst without master", 32'(log_n - base), 4);
      bus_wr(8'h00, 32'h80000000, 1'b1);
    end

    // R11 soft reset
    bus_wr(8'h14, 32'h12345678, 1'b1);
    bus_wr(8'h04, 32'h1003, 1'b1);
    bus_wr(8'h00, 32'h80000003, 1'b1);
    @(negedge clk);
    bus_rd(8'h00, 1'b1, v); chk(v == 0, "R11 ctrl cleared self-clear", v, 0);
    bus_rd(8'h10, 1'b1, v); chk(v == 0, "R11 fifos empty", v, 0);
    bus_rd(8'h04, 1'b1, v); chk(v == 0, "R11 divider cleared", v, 0);

    // R9 divider
    for (int n = 0; n < 3; n++) begin
      int per;
      rise_cnt = 0;
      bus_wr(8'h00, 32'h200, 1'b1);
      run_burst(1, 1, n);
      per = int'((t2 - t1) / 20);
      chk(per == 2 * (n + 1), "R9 sclk period", per, 2 * (n + 1));
    end

    // R8 stall
    begin
      int base;
      base = log_n;
      bus_wr(8'h04, 32'h1001, 1'b1);
      bus_wr(8'h08, 2, 1'b1);
      bus_wr(8'h0C, 2, 1'b1);
      bus_wr(8'h14, 32'h0000003C, 1'b0);
      rise_cnt = 0;
      bus_wr(8'h00, 32'h403, 1'b1);
      repeat (200) @(negedge clk);
      chk(rise_cnt == 8 && sclk == 1'b0, "R8 stalled after one byte", rise_cnt, 8);
      bus_rd(8'h00, 1'b1, v);
      chk(v[10] && !cs_n, "R8 burst held during stall", v, 32'h403);
      bus_wr(8'h14, 32'h000000C3, 1'b0);
      wait_done(ok);
      chk(rise_cnt == 16 && mosi_log[base+1] == 8'hC3, "R8 resumes", mosi_log[base+1], 8'hC3);
      bus_wr(8'h00, 32'h200, 1'b1);
    end

    // random bursts
    for (int t = 0; t < 12; t++) begin
      int len, txl;
      len = $urandom_range(1, 12);
      txl = $urandom_range(0, len);
      run_burst(len, txl, $urandom_range(0, 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule